// File: doc/BRIEF.md
# Single-Wire Half-Duplex ADC Host Controller

This block is the host side of a serial link to a 10-bit sampling converter that shares one bidirectional data wire for both directions. After a one-cycle start request it pulls chip-select low, generates a serial clock from the system clock, and drives a logic-one start bit followed by the single/differential bit, the odd/sign bit and a placeholder bit. It then gives up the wire while the serial clock is high, so that the converter can take the wire over on the following falling edge. It skips the converter's leading null bits, shifts in the ten result bits most significant first, and ends the exchange as soon as the last bit has been taken.

The user side sees a start strobe, two mode bits and a programmable half-period for the serial clock. At the end it gets a 10-bit result together with a one-cycle done pulse. The pad is exposed as separate output, output-enable and input signals, so that a tri-state buffer at the chip edge can join them onto a single wire.

Top module: `adc_wire_host`

## Requirements
- R1: While reset is asserted, and in the cycle after it, chip-select is high, the serial clock is low, the data output enable is low and done is low.
- R2: When start is seen while idle, the next cycle has chip-select low, the output enable high and the data output at 1 (the start bit), and the two mode inputs are latched.
- R3: The wire carries the converter's samples on serial clock rising edges 1 to 4, in this order: 1, the single/differential bit, the odd/sign bit, and a dummy bit of 0. Each bit changes only on a falling edge.
- R4: The output enable drops in the same system cycle as the 4th rising edge of the serial clock, and so is low before the 4th falling edge.
- R5: Each half-period of the serial clock lasts half_period_i system cycles, with 0 treated as 1. One exchange has exactly 16 rising edges, and chip-select stays low for 32 half-periods.
- R6: The values on rising edges 5 and 6 (null bits) are discarded. Rising edges 7 to 16 capture result bits 9 down to 0, and that value appears on result_o.
- R7: On the 16th falling edge, chip-select goes high, the serial clock stays low and done pulses for exactly one cycle, together with the new result.
- R8: A start that arrives during an exchange is ignored. The mode bits sent stay those of the first request, and no second exchange follows.
- R9: The host output enable and the converter's output enable are never high in the same cycle.
- R10: Whenever chip-select is high, the serial clock is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion exchange |
| single_i | input | 1 | Single-ended (1) or differential (0) request |
| odd_i | input | 1 | Channel / polarity select bit |
| half_period_i | input | HP_W | Serial clock half-period in system cycles (0 acts as 1) |
| result_o | output | RES_W | Last converted value |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| cs_n_o | output | 1 | Active-low chip-select |
| sclk_o | output | 1 | Generated serial clock |
| sdata_o | output | 1 | Value driven onto the shared wire |
| sdata_oe_o | output | 1 | Enable for driving the shared wire |
| sdata_i | input | 1 | Value read back from the shared wire |

## Verification
With h the effective half-period, chip-select falls one system cycle after start and rising edge k arrives (2k-1)·h cycles after that. The handover happens on the 4th rising edge. Done and the rising chip-select come 32·h cycles after chip-select falls. The bench samples on the falling system clock edge and counts the cycles with chip-select low and the serial clock rising edges, then compares these counts with 32·h and 16. A behavioural converter model samples the wire on the serial clock edges, so the start, mode and handover checks fall exactly at the serial edges where the converter would act.

// File: rtl/adcw_pkg.sv
package adcw_pkg;
  localparam int CFG_BITS  = 4;
  localparam int NULL_BITS = 2;
  typedef enum logic {ST_IDLE, ST_XFER} xfer_state_e;
endpackage

// File: rtl/adcw_clkdiv.sv
module adcw_clkdiv #(
  parameter int HP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [HP_W-1:0] half_period,
  output logic            tick
);
  logic [HP_W-1:0] cnt_q;
  logic [HP_W-1:0] hp_eff;

  assign hp_eff = (half_period == '0) ? HP_W'(1) : half_period;
  assign tick   = run && (cnt_q == hp_eff - HP_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + HP_W'(1);
    end
  end
endmodule

// File: rtl/adcw_rx_shift.sv
module adcw_rx_shift #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [RES_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (shift_en) begin
      value <= {value[RES_W-2:0], bit_in};
    end
  end
endmodule

// File: rtl/adcw_seq.sv
module adcw_seq
  import adcw_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic single,
  input  logic odd,
  input  logic tick,
  output logic run,
  output logic cs_n,
  output logic sclk,
  output logic sd_out,
  output logic sd_oe,
  output logic shift_en,
  output logic finish
);
  localparam int TOTAL = CFG_BITS + NULL_BITS + RES_W;
  localparam int CNT_W = $clog2(TOTAL + 1);

  xfer_state_e        state_q;
  logic [CNT_W-1:0]   rise_cnt_q;
  logic [CFG_BITS-1:0] cfg_q;

  assign run      = (state_q == ST_XFER);
  assign shift_en = run && tick && !sclk &&
                    (rise_cnt_q >= CNT_W'(CFG_BITS + NULL_BITS));
  assign finish   = run && tick && sclk && (rise_cnt_q == CNT_W'(TOTAL));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      rise_cnt_q <= '0;
      cfg_q      <= '0;
      cs_n       <= 1'b1;
      sclk       <= 1'b0;
      sd_out     <= 1'b0;
      sd_oe      <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (start) begin
        state_q    <= ST_XFER;
        rise_cnt_q <= '0;
        cfg_q      <= {1'b0, odd, single, 1'b1};
        cs_n       <= 1'b0;
        sd_out     <= 1'b1;
        sd_oe      <= 1'b1;
      end
    end else if (tick) begin
      if (!sclk) begin
        sclk       <= 1'b1;
        rise_cnt_q <= rise_cnt_q + CNT_W'(1);
        if (rise_cnt_q == CNT_W'(CFG_BITS - 1)) begin
          sd_oe  <= 1'b0;
          sd_out <= 1'b0;
        end
      end else begin
        sclk <= 1'b0;
        if (rise_cnt_q == CNT_W'(TOTAL)) begin
          state_q <= ST_IDLE;
          cs_n    <= 1'b1;
        end else if (rise_cnt_q < CNT_W'(CFG_BITS)) begin
          sd_out <= cfg_q[rise_cnt_q[$clog2(CFG_BITS)-1:0]];
        end
      end
    end
  end
endmodule

// File: rtl/adc_wire_host.sv
module adc_wire_host #(
  parameter int RES_W = 10,
  parameter int HP_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             single_i,
  input  logic             odd_i,
  input  logic [HP_W-1:0]  half_period_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             sdata_oe_o,
  input  logic             sdata_i
);
  logic             tick;
  logic             run;
  logic             shift_en;
  logic             finish;
  logic [RES_W-1:0] shreg;

  adcw_clkdiv #(.HP_W(HP_W)) div_i (
    .clk(clk), .rst(rst), .run(run),
    .half_period(half_period_i), .tick(tick)
  );

  adcw_seq #(.RES_W(RES_W)) seq_i (
    .clk(clk), .rst(rst), .start(start_i), .single(single_i), .odd(odd_i),
    .tick(tick), .run(run), .cs_n(cs_n_o), .sclk(sclk_o),
    .sd_out(sdata_o), .sd_oe(sdata_oe_o), .shift_en(shift_en), .finish(finish)
  );

  adcw_rx_shift #(.RES_W(RES_W)) rx_i (
    .clk(clk), .rst(rst), .shift_en(shift_en), .bit_in(sdata_i), .value(shreg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish) result_o <= shreg;
    end
  end
endmodule

// File: rtl/adcw_checker.sv
module adcw_checker #(
  parameter int RES_W = 10
) (
  input logic clk,
  input logic rst,
  input logic cs_n_o,
  input logic sclk_o,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic done_o
);
  localparam int TOTAL = adcw_pkg::CFG_BITS + adcw_pkg::NULL_BITS + RES_W;
  logic       sclk_d;
  logic [7:0] rises;

  always_ff @(posedge clk) begin
    if (rst || cs_n_o) begin
      rises  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_o;
      if (sclk_o && !sclk_d) rises <= rises + 8'd1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (cs_n_o && !sclk_o && !sdata_oe_o && !done_o));
  assert_start_bit_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> (sdata_oe_o && sdata_o));
  assert_release_high_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sdata_oe_o) |-> sclk_o);
  assert_rise_count_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> (rises == 8'(TOTAL)));
  assert_done_with_cs_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $rose(cs_n_o));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> (!sclk_o && !sdata_oe_o));
endmodule

bind adc_wire_host adcw_checker #(.RES_W(RES_W)) chk_i (
  .clk(clk), .rst(rst), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
  .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .done_o(done_o)
);

// File: tb/adc_wire_host_tb_top.sv
`timescale 1ns/1ps
module adc_wire_host_tb_top;
  localparam int RES_W = 10;
  localparam int HP_W  = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic             single_i = 1'b0;
  logic             odd_i = 1'b0;
  logic [HP_W-1:0]  half_period_i = '0;
  logic [RES_W-1:0] result_o;
  logic             done_o, cs_n_o, sclk_o, sdata_o, sdata_oe_o;
  logic             line;

  int n_checks = 0;
  int n_fail   = 0;

  // converter model state
  logic             dev_oe = 1'b0;
  logic             dev_o  = 1'b0;
  logic             dev_started = 1'b0;
  int               dev_cnt = 0;
  logic             dev_first_ok = 1'b0;
  logic             rx_sgl = 1'b0, rx_odd = 1'b0;
  logic [RES_W-1:0] dev_value = '0;
  int               bus_fights = 0;
  int               sclk_rises = 0;
  int               r4_bad = 0;
  int               r3_bad = 0;

  always #5 clk = ~clk;

  assign line = sdata_oe_o ? sdata_o : (dev_oe ? dev_o : 1'b1);

  adc_wire_host #(.RES_W(RES_W), .HP_W(HP_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .single_i(single_i), .odd_i(odd_i),
    .half_period_i(half_period_i), .result_o(result_o), .done_o(done_o),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
    .sdata_i(line)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model
  always @(negedge cs_n_o) begin
    dev_started = 1'b0; dev_cnt = 0; dev_oe = 1'b0; dev_first_ok = 1'b0;
    sclk_rises = 0;
  end
  always @(posedge cs_n_o) dev_oe = 1'b0;

  always @(posedge sclk_o) begin
    if (!cs_n_o) begin
      sclk_rises++;
      if (!dev_started) begin
        if (line) begin
          dev_started = 1'b1; dev_cnt = 1;
          dev_first_ok = (sclk_rises == 1);
        end
      end else begin
        dev_cnt++;
        if (dev_cnt == 2) rx_sgl = line;
        if (dev_cnt == 3) rx_odd = line;
      end
      if (dev_cnt >= 1 && dev_cnt <= 3 && !sdata_oe_o) r3_bad++;
    end
  end

  always @(negedge sclk_o) begin
    if (!cs_n_o && dev_started) begin
      if (dev_cnt == 4 && sdata_oe_o) r4_bad++;
      if (dev_cnt >= 4) dev_oe = 1'b1;
      if (dev_cnt >= 6 && dev_cnt <= 15) dev_o = dev_value[15 - dev_cnt];
      else dev_o = 1'b0;
    end
  end

  always @(negedge clk) if (sdata_oe_o && dev_oe) bus_fights++;

  task automatic run_xfer(input int hp, input bit sgl, input bit od,
                          input logic [RES_W-1:0] val, input bit poke);
    int hpe, low_cycles, waited;
    bit seen;
    hpe = (hp == 0) ? 1 : hp;
    half_period_i = HP_W'(hp);
    single_i = sgl; odd_i = od; dev_value = val;
    bus_fights = 0; r3_bad = 0; r4_bad = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2: next cycle shows the start bit
    check(!cs_n_o && sdata_oe_o && sdata_o, "R2 start bit driven",
          {cs_n_o, sdata_oe_o, sdata_o}, 3'b011);
    low_cycles = 0; seen = 0; waited = 0;
    while (!seen && waited < 400) begin
      if (!cs_n_o) low_cycles++;
      if (poke && waited == 7) begin
        start_i = 1'b1; single_i = ~sgl; odd_i = ~od;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      waited++;
      if (done_o) seen = 1;
    end
    start_i = 1'b0;
    check(seen, "R7 done reached", int'(seen), 1);
    check(low_cycles == 32 * hpe, "R5 chip-select low cycles", low_cycles, 32 * hpe);
    check(sclk_rises == 16, "R5 serial rising edges", sclk_rises, 16);
    check(result_o == val, "R6 result value", int'(result_o), int'(val));
    check(cs_n_o && !sclk_o && !sdata_oe_o, "R7 ends with cs high",
          {cs_n_o, sclk_o, sdata_oe_o}, 3'b100);
    check(dev_first_ok && rx_sgl == sgl && rx_odd == od && r3_bad == 0,
          "R3 start and mode bits", {dev_first_ok, rx_sgl, rx_odd}, {1'b1, sgl, od});
    check(r4_bad == 0, "R4 released before 4th falling edge", r4_bad, 0);
    check(bus_fights == 0, "R9 no wire contention", bus_fights, 0);
    @(negedge clk);
    check(!done_o, "R7 done single cycle", int'(done_o), 0);
    if (poke) begin
      for (int i = 0; i < 6; i++) begin
        check(cs_n_o, "R8 busy start ignored", int'(cs_n_o), 1);
        @(negedge clk);
      end
    end
  endtask

  initial begin : watchdog
    #1500000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [RES_W-1:0] vals [5];
    vals[0] = 10'h000; vals[1] = 10'h3FF; vals[2] = 10'h200;
    vals[3] = 10'h155; vals[4] = 10'h2AA;
    repeat (3) @(negedge clk);
    check(cs_n_o && !sclk_o && !sdata_oe_o && !done_o, "R1 during reset",
          {cs_n_o, sclk_o, sdata_oe_o, done_o}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n_o && !sclk_o && !sdata_oe_o && !done_o, "R1 after reset",
          {cs_n_o, sclk_o, sdata_oe_o, done_o}, 4'b1000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(cs_n_o && !sclk_o && !sdata_oe_o, "R10 idle quiet",
            {cs_n_o, sclk_o, sdata_oe_o}, 3'b100);
    end
    for (int hp = 0; hp < 4; hp++)
      for (int m = 0; m < 4; m++)
        for (int v = 0; v < 5; v++)
          run_xfer(hp, m[1], m[0], vals[v], (v == 3));
    run_xfer(5, 1'b1, 1'b0, 10'h0F3, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule